// File: doc/BRIEF.md
# Trace qualification status reporter

This block sits in an instruction trace encoder. It builds the supporting-information packet that the encoder issues when trace qualification changes or when trace data has been dropped. It watches a level that shows whether qualification is active, a one-cycle trace-lost pulse, and a flag on the address packet just sent. That flag says whether the address packet would have gone out anyway because of an uninferable discontinuity.

When qualification ends, the encoder has already reported the address of the final traced instruction. This block then raises a support-packet request. The request's 2-bit status tells the decoder how to read that preceding address packet:
- If the address packet was sent only to mark the end, the status is "ended, explicit".
- If the address packet would have been sent regardless, the status is "ended, forced".

A lost indication produces its own request. The request and its fields stay fixed until a downstream ready accepts them. Events that arrive while a request is outstanding are held and issued in priority order.

Top module: `qual_status_top`

## Requirements
- R1: After reset, `reqValid` is 0 and `qualStatus` is 2'b00.
- R2: In every issued packet, `subformat` is 2'b11 (support) and `encMode` equals `MODE_VAL`, whose default 0 means branch trace.
- R3: A falling edge of `qualActive` with `addrForced` low in that cycle yields a packet with `qualStatus` 2'b01 (ended, explicit).
- R4: A falling edge of `qualActive` with `addrForced` high in that cycle yields a packet with `qualStatus` 2'b11 (ended, forced).
- R5: A `traceLost` pulse yields a packet with `qualStatus` 2'b10 (packets lost).
- R6: A lost event is pending at the same time as an end event. The lost packet (2'b10) is issued first, and the end packet follows it.
- R7: While `reqValid` is high and `reqReady` is low, `reqValid` stays high and `qualStatus` and `enableBit` do not change.
- R8: `enableBit` carries the value of `encoderOn` at the clock edge where the packet is loaded.
- R9: While no request is outstanding, `qualStatus` reads 2'b00 (no change).
- R10: Events that arrive while a request is held are retained. They are issued one per accepted packet, and a pending lost packet goes ahead of a pending end packet.
- R11: When the request slot is free, the request is raised at the first clock edge after the event cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qualActive | input | 1 | Trace qualification active level |
| traceLost | input | 1 | One-cycle pulse: trace packets were dropped |
| addrForced | input | 1 | Final address packet would have been sent anyway; valid in the cycle qualification falls |
| encoderOn | input | 1 | Encoder enable state to place in the packet |
| reqReady | input | 1 | Downstream accepts the packet |
| reqValid | output | 1 | Support packet request |
| subformat | output | 2 | Packet subformat, always support (2'b11) |
| enableBit | output | 1 | Encoder enable field |
| encMode | output | MODE_W | Encoder mode field |
| qualStatus | output | 2 | Qualification status field |

## Verification
The bench builds the block with a 3-bit mode field and mode value 0, so the constant mode output is checked at a width other than the default. The bench also varies the ready input:
- With ready held high, packets drain back to back, which tests the one-cycle latency and same-cycle priority.
- With ready held low, up to three packets build up: one held packet, one pending end and one pending loss. This brings the retention and reordering paths within reach, together with the enable capture at load time.

// File: rtl/qual_status_pkg.sv
package qual_status_pkg;
  typedef enum logic [1:0] {
    QS_NONE         = 2'b00,
    QS_ENDED_EXPL   = 2'b01,
    QS_LOST         = 2'b10,
    QS_ENDED_FORCED = 2'b11
  } qualCode_e;

  localparam logic [1:0] SUPPORT_SUBFMT = 2'b11;

  typedef struct packed {
    logic loadLost;
    logic loadEnd;
    logic endForced;
    logic clear;
  } ctlStrobes_t;
endpackage

// File: rtl/qual_status_ctrl.sv
module qual_status_ctrl
  import qual_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        qualActive,
  input  logic        traceLost,
  input  logic        addrForced,
  input  logic        reqReady,
  output logic        reqValid,
  output ctlStrobes_t strobes
);
  logic prevQual;
  logic pendLost, pendEnd, pendForced;
  logic endEvt, lostAll, endAll, forcedAll, slotFree, anyLoad;

  // Combine held events with the ones arriving this cycle.
  always_comb begin
    endEvt    = prevQual & ~qualActive;
    lostAll   = pendLost | traceLost;
    endAll    = pendEnd | endEvt;
    forcedAll = endEvt ? addrForced : pendForced;
    slotFree  = ~reqValid | reqReady;
    strobes.loadLost  = slotFree & lostAll;
    strobes.loadEnd   = slotFree & ~lostAll & endAll;
    strobes.endForced = forcedAll;
    anyLoad           = strobes.loadLost | strobes.loadEnd;
    strobes.clear     = reqValid & reqReady & ~anyLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQual   <= 1'b0;
      pendLost   <= 1'b0;
      pendEnd    <= 1'b0;
      pendForced <= 1'b0;
      reqValid   <= 1'b0;
    end else begin
      prevQual   <= qualActive;
      pendLost   <= lostAll & ~strobes.loadLost;
      pendEnd    <= endAll & ~strobes.loadEnd;
      pendForced <= forcedAll;
      reqValid   <= anyLoad | (reqValid & ~reqReady);
    end
  end

  // R7: an unaccepted request is never withdrawn
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid);
endmodule

// File: rtl/qual_status_dp.sv
module qual_status_dp
  import qual_status_pkg::*;
#(
  parameter int MODE_W   = 2,
  parameter int MODE_VAL = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              encoderOn,
  input  logic              reqValid,
  input  logic              reqReady,
  output logic [1:0]        subformat,
  output logic              enableBit,
  output logic [MODE_W-1:0] encMode,
  output logic [1:0]        qualStatus
);
  localparam logic [MODE_W-1:0] MODE_CODE = MODE_W'(MODE_VAL);

  qualCode_e statusQ;
  logic      enableQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= QS_NONE;
      enableQ <= 1'b0;
    end else if (strobes.loadLost) begin
      statusQ <= QS_LOST;
      enableQ <= encoderOn;
    end else if (strobes.loadEnd) begin
      statusQ <= strobes.endForced ? QS_ENDED_FORCED : QS_ENDED_EXPL;
      enableQ <= encoderOn;
    end else if (strobes.clear) begin
      statusQ <= QS_NONE;
      enableQ <= 1'b0;
    end
  end

  assign subformat  = SUPPORT_SUBFMT;
  assign encMode    = MODE_CODE;
  assign enableBit  = enableQ;
  assign qualStatus = statusQ;

  // R7: fields are frozen while the request waits
  assert_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> ($stable(qualStatus) && $stable(enableBit)));
  // R9: no request outstanding means status reads no-change
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (qualStatus == 2'b00));
endmodule

// File: rtl/qual_status_top.sv
module qual_status_top #(
  parameter int MODE_W   = 2,
  parameter int MODE_VAL = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qualActive,
  input  logic              traceLost,
  input  logic              addrForced,
  input  logic              encoderOn,
  input  logic              reqReady,
  output logic              reqValid,
  output logic [1:0]        subformat,
  output logic              enableBit,
  output logic [MODE_W-1:0] encMode,
  output logic [1:0]        qualStatus
);
  import qual_status_pkg::*;

  ctlStrobes_t strobes;

  qual_status_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .qualActive(qualActive), .traceLost(traceLost),
    .addrForced(addrForced), .reqReady(reqReady), .reqValid(reqValid),
    .strobes(strobes)
  );

  qual_status_dp #(.MODE_W(MODE_W), .MODE_VAL(MODE_VAL)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .encoderOn(encoderOn),
    .reqValid(reqValid), .reqReady(reqReady), .subformat(subformat),
    .enableBit(enableBit), .encMode(encMode), .qualStatus(qualStatus)
  );

  // R6: with the slot free, a loss always wins the next load
  assert_lost_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (traceLost && (!reqValid || reqReady)) |=> (qualStatus == 2'b10));
  // R11: qualification end reaches the request one edge later
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!qualActive && $past(qualActive) && (!reqValid || reqReady)) |=> reqValid);
endmodule

// File: tb/qual_status_top_test.sv
module qual_status_top_test;
  localparam int MODE_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic qualActive = 1'b0, traceLost = 1'b0, addrForced = 1'b0;
  logic encoderOn = 1'b1, reqReady = 1'b1;
  logic reqValid, enableBit;
  logic [1:0] subformat, qualStatus;
  logic [MODE_W-1:0] encMode;

  int checks = 0, fails = 0;
  logic [2:0] expQ[$];   // {enable, status}
  bit monOn = 1'b0;

  always #10 clk = ~clk;

  qual_status_top #(.MODE_W(MODE_W), .MODE_VAL(0)) uut (
    .clk(clk), .rstN(rstN), .qualActive(qualActive), .traceLost(traceLost),
    .addrForced(addrForced), .encoderOn(encoderOn), .reqReady(reqReady),
    .reqValid(reqValid), .subformat(subformat), .enableBit(enableBit),
    .encMode(encMode), .qualStatus(qualStatus)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushExp(input logic en, input logic [1:0] st);
    expQ.push_back({en, st});
  endtask

  // Drivers change inputs 5 ns after a rising edge.
  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic startQual();
    qualActive = 1'b1; tick();
  endtask

  task automatic endQual(input logic forced, input logic alsoLost, input logic checkLat);
    qualActive = 1'b0; addrForced = forced; traceLost = alsoLost;
    tick();
    addrForced = 1'b0; traceLost = 1'b0;
    if (checkLat) begin
      #5; check("R11 latency", {7'b0, reqValid}, 8'd1);
    end
  endtask

  task automatic lostPulse();
    traceLost = 1'b1; tick(); traceLost = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && expQ.size() != 0; i++) tick();
    check("R10 all expected packets issued", 8'(expQ.size()), 8'd0);
    repeat (2) tick();
  endtask

  // Monitor: samples 15 ns after each rising edge.
  logic prevHeld = 1'b0;
  logic [2:0] prevFields = '0;
  always @(posedge clk) begin
    #15;
    if (monOn) begin
      if (prevHeld) begin
        check("R7 request held", {7'b0, reqValid}, 8'd1);
        check("R7 fields stable", {5'b0, enableBit, qualStatus}, {5'b0, prevFields});
      end
      if (!reqValid) check("R9 idle status", {6'b0, qualStatus}, 8'd0);
      if (reqValid && reqReady) begin
        check("R2 subformat", {6'b0, subformat}, 8'd3);
        check("R2 mode", {5'b0, encMode}, 8'd0);
        if (expQ.size() == 0) begin
          check("R10 unexpected packet", {5'b0, enableBit, qualStatus}, 8'hff);
        end else begin
          logic [2:0] e;
          e = expQ.pop_front();
          check("R3/R4/R5/R6/R8 packet fields", {5'b0, enableBit, qualStatus}, {5'b0, e});
        end
      end
      prevHeld   = reqValid && !reqReady;
      prevFields = {enableBit, qualStatus};
    end
  end

  initial begin : watchdog
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    #5;
    check("R1 reset valid", {7'b0, reqValid}, 8'd0);
    check("R1 reset status", {6'b0, qualStatus}, 8'd0);
    monOn = 1'b1;
    tick();

    // R3: explicit end
    startQual(); pushExp(1'b1, 2'b01); endQual(1'b0, 1'b0, 1'b1); drain();
    // R4: forced end
    startQual(); pushExp(1'b1, 2'b11); endQual(1'b1, 1'b0, 1'b1); drain();
    // R5: loss
    pushExp(1'b1, 2'b10); lostPulse(); drain();
    // R6: loss and end together, loss first
    startQual(); pushExp(1'b1, 2'b10); pushExp(1'b1, 2'b01);
    endQual(1'b0, 1'b1, 1'b0); drain();

    // R10 / R7: build up events behind a held request
    reqReady = 1'b0;
    startQual(); endQual(1'b1, 1'b0, 1'b1);
    pushExp(1'b1, 2'b11);
    repeat (3) tick();
    startQual(); endQual(1'b0, 1'b0, 1'b0);
    lostPulse();
    pushExp(1'b1, 2'b10); pushExp(1'b1, 2'b01);
    repeat (3) tick();
    reqReady = 1'b1;
    drain();

    // R8: enable field follows encoderOn
    encoderOn = 1'b0;
    pushExp(1'b0, 2'b10); lostPulse(); drain();
    encoderOn = 1'b1;
    startQual(); pushExp(1'b1, 2'b01); endQual(1'b0, 1'b0, 1'b0); drain();

    #5;
    check("R9 final idle status", {6'b0, qualStatus}, 8'd0);
    check("R9 final idle valid", {7'b0, reqValid}, 8'd0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule